// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block connects a synchronous host request port to an asynchronous byte-wide DRAM that has extended data output. The host issues single-byte reads and writes with a valid/ready handshake. The controller splits each word address into a row part and a column part and sends both over one shared address bus. It opens the row with a falling row strobe, then selects the column with a falling column strobe. After the access the row stays open. A later request to the same row needs only a new column strobe, which is a page hit. A request to any other row first precharges the open row and then activates the new one.

Read data stays valid on the DRAM pins after the column strobe rises, as long as the row strobe and output enable stay low. The controller therefore captures read data during the column precharge phase. A free-running interval timer keeps the DRAM refreshed. When the timer expires, the controller finishes the access it has already accepted, closes the open row, and issues a refresh in which the column strobe falls before the row strobe. While that refresh is pending, no new host request is accepted.

All DRAM timings are given as parameters in picoseconds. The controller converts each one to a clock-cycle count, rounding up.

Top module: `edo_page_ctrl`

## Requirements
- R1: A host address is split so that its upper ROW_W bits are the row and its lower COL_W bits are the column. The row is on `dram_addr` when `dram_ras_n` falls. The column is on `dram_addr` when `dram_cas_n` falls.
- R2: Each write puts the host byte on `dram_dq_out` as the column strobe falls. A read returns, on `rd_data` with a one-cycle `rd_valid` pulse, the byte most recently written to that address. Reads complete in request order.
- R3: A request to the row that is already open causes no new fall of `dram_ras_n`. Only a column strobe is issued.
- R4: A request to a different row raises `dram_ras_n`. The strobe stays high for at least ceil(T_RP_PS / CLK_PS) cycles before it falls again with the new row.
- R5: `dram_ras_n` stays low for at least ceil(T_RC_PS / CLK_PS) − ceil(T_RP_PS / CLK_PS) cycles. `dram_cas_n` stays low for at least ceil(max(T_CAS_PS, T_CAC_PS) / CLK_PS) cycles.
- R6: In a write, `dram_we_n` is already low one cycle before `dram_cas_n` falls. When the column strobe falls, `dram_dq_oe` is 1 and `dram_oe_n` is 1.
- R7: In a read, `dram_oe_n` is 0 and `dram_we_n` is 1 when the column strobe falls. The data is captured in the cycle after the column strobe has risen, while `dram_ras_n` and `dram_oe_n` are still low.
- R8: A refresh drives `dram_cas_n` low at least one cycle before `dram_ras_n` falls, with `dram_we_n` high. Two consecutive refreshes are never more than ceil(T_REFI_PS / CLK_PS) + 48 cycles apart, and the first refresh after reset meets the same limit.
- R9: A pending refresh takes priority over new host requests. The refresh limit of R8 holds even when the host keeps requesting the open row without pause. During reset and right after it, all four strobes are high, `dram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R10: `dram_dq_oe` is 1 only during a write column phase, that is, only while `dram_we_n` is 0 and `dram_oe_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Byte address, row in the upper bits |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle strobe marking read data |
| rd_data | output | 8 | Read byte |
| dram_addr | output | PIN_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_in | input | 8 | Data from the DRAM |
| dram_dq_out | output | 8 | Data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |

## Verification
The hardest case to reach is a refresh that falls due in the middle of a continuous run of page hits. In that case the controller must break the page burst, precharge, and refresh in time, even though the host never leaves a gap. The bench reaches this case by issuing a long back-to-back stream of alternating writes and reads to one row, which lasts several refresh intervals. A behavioural DRAM model measures the spacing between refreshes at the pins and checks that every later read still returns the correct data. For clean page-hit and page-miss counts, the bench first waits for a refresh to finish and then runs a short burst. This lets it count row activations with no refresh in between.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,  // row closed, precharge done
    ST_ACT,   // row strobe low, row-to-column delay
    ST_CSET,  // column address and write enable set up
    ST_CAS,   // column strobe low
    ST_CPRE,  // column strobe high, read capture at end
    ST_OPEN,  // row open, waiting for work
    ST_PRE,   // row strobe high, precharge
    ST_RCAS,  // refresh: column strobe low first
    ST_RRAS   // refresh: both strobes low
  } seq_state_e;

  function automatic int cyc_ceil(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 3120
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= CW'(INTERVAL - 1);
      pend <= 1'b0;
    end else begin
      if (clr) pend <= 1'b0;
      if (cnt == '0) begin
        cnt  <= CW'(INTERVAL - 1);
        pend <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R8: a pending refresh is only dropped once the sequencer takes it
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);

endmodule

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
  parameter int ROW_W = 12,
  parameter int COL_W = 11
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col
);
  always_comb begin
    row = addr[ROW_W+COL_W-1:COL_W];
    col = addr[COL_W-1:0];
  end
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 11,
  parameter int PIN_W   = 12,
  parameter int RCD     = 5,
  parameter int CLO     = 3,
  parameter int CHI     = 1,
  parameter int RP      = 6,
  parameter int RAS_MIN = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [7:0]       req_wdata,
  output logic             req_ready,
  input  logic             ref_pend,
  output logic             ref_clr,
  output logic [PIN_W-1:0] dram_addr,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic             dram_oe_n,
  input  logic [7:0]       dram_dq_in,
  output logic [7:0]       dram_dq_out,
  output logic             dram_dq_oe,
  output logic [7:0]       rd_data,
  output logic             rd_valid
);
  localparam int TMAX = imax(imax(imax(RCD, CLO), imax(CHI, RP)), RAS_MIN);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int AW   = $clog2(RAS_MIN + 1);

  seq_state_e       state;
  logic [TW-1:0]    tmr;
  logic [AW-1:0]    ras_age;
  logic             pend_q;
  logic             p_write;
  logic [ROW_W-1:0] p_row;
  logic [COL_W-1:0] p_col;
  logic [7:0]       p_wdata;
  logic [ROW_W-1:0] open_row;
  logic             accept;
  logic             age_ok;
  logic             page_hit;

  assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_pend && !pend_q;
  assign accept    = req_valid && req_ready;
  assign age_ok    = ras_age >= AW'(RAS_MIN - 1);
  assign page_hit  = pend_q && (p_row == open_row);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tmr         <= '0;
      ras_age     <= '0;
      pend_q      <= 1'b0;
      p_write     <= 1'b0;
      p_row       <= '0;
      p_col       <= '0;
      p_wdata     <= '0;
      open_row    <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      ref_clr     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      ref_clr  <= 1'b0;
      if (accept) begin
        pend_q  <= 1'b1;
        p_write <= req_write;
        p_row   <= req_row;
        p_col   <= req_col;
        p_wdata <= req_wdata;
      end
      if (!dram_ras_n && (ras_age != AW'(RAS_MIN))) ras_age <= ras_age + 1'b1;

      unique case (state)
        ST_IDLE: begin
          if (pend_q) begin
            dram_ras_n <= 1'b0;
            ras_age    <= '0;
            dram_addr  <= PIN_W'(p_row);
            open_row   <= p_row;
            tmr        <= TW'(RCD - 1);
            state      <= ST_ACT;
          end else if (ref_pend) begin
            dram_cas_n <= 1'b0;
            state      <= ST_RCAS;
          end
        end
        ST_ACT: begin
          if (tmr == '0) begin
            dram_addr   <= PIN_W'(p_col);
            dram_we_n   <= !p_write;
            dram_oe_n   <= p_write;
            dram_dq_oe  <= p_write;
            dram_dq_out <= p_wdata;
            pend_q      <= 1'b0;
            state       <= ST_CSET;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_CSET: begin
          dram_cas_n <= 1'b0;
          tmr        <= TW'(CLO - 1);
          state      <= ST_CAS;
        end
        ST_CAS: begin
          if (tmr == '0) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            tmr        <= TW'(CHI - 1);
            state      <= ST_CPRE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_CPRE: begin
          if (tmr == '0) begin
            if (!p_write) begin
              rd_data  <= dram_dq_in;
              rd_valid <= 1'b1;
            end
            dram_oe_n <= 1'b1;
            state     <= ST_OPEN;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_OPEN: begin
          if (page_hit) begin
            dram_addr   <= PIN_W'(p_col);
            dram_we_n   <= !p_write;
            dram_oe_n   <= p_write;
            dram_dq_oe  <= p_write;
            dram_dq_out <= p_wdata;
            pend_q      <= 1'b0;
            state       <= ST_CSET;
          end else if ((pend_q || ref_pend) && age_ok) begin
            dram_ras_n <= 1'b1;
            tmr        <= TW'(RP - 1);
            state      <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (tmr == '0) state <= ST_IDLE;
          else           tmr   <= tmr - 1'b1;
        end
        ST_RCAS: begin
          dram_ras_n <= 1'b0;
          ras_age    <= '0;
          ref_clr    <= 1'b1;
          tmr        <= TW'(RAS_MIN - 1);
          state      <= ST_RRAS;
        end
        ST_RRAS: begin
          if (tmr == '0) begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            tmr        <= TW'(RP - 1);
            state      <= ST_PRE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Strobe-width tracking used only by the checks below
  localparam int HW = $clog2(RP + 1);
  logic [HW-1:0] hi_cnt;
  logic [AW-1:0] lo_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= HW'(RP);
      lo_cnt <= '0;
    end else if (dram_ras_n) begin
      lo_cnt <= '0;
      if (hi_cnt != HW'(RP)) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != AW'(RAS_MIN)) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assert_ras_precharge_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (hi_cnt >= HW'(RP)));

  assert_ras_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> (lo_cnt >= AW'(RAS_MIN)));

  assert_we_setup_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_cas_n) && !dram_we_n) |-> !$past(dram_we_n));

  assert_edo_capture_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!dram_ras_n && dram_cas_n && !dram_oe_n));

  assert_cbr_order_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_ras_n) && !dram_cas_n) |-> (!$past(dram_cas_n) && dram_we_n));

  assert_bus_drive_R10: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> (!dram_we_n && dram_oe_n));

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 11,
  parameter int PIN_W     = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int CLK_PS    = 5000,
  parameter int T_RC_PS   = 84000,
  parameter int T_RAC_PS  = 50000,
  parameter int T_PC_PS   = 20000,
  parameter int T_AA_PS   = 25000,
  parameter int T_CAC_PS  = 13000,
  parameter int T_CAS_PS  = 8000,
  parameter int T_RP_PS   = 30000,
  parameter int T_REFI_PS = 15600000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [7:0]             req_wdata,
  output logic                   rd_valid,
  output logic [7:0]             rd_data,
  output logic [PIN_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  input  logic [7:0]             dram_dq_in,
  output logic [7:0]             dram_dq_out,
  output logic                   dram_dq_oe
);
  localparam int C_RC   = cyc_ceil(T_RC_PS, CLK_PS);
  localparam int C_RAC  = cyc_ceil(T_RAC_PS, CLK_PS);
  localparam int C_PC   = cyc_ceil(T_PC_PS, CLK_PS);
  localparam int C_AA   = cyc_ceil(T_AA_PS, CLK_PS);
  localparam int C_RP   = imax(1, cyc_ceil(T_RP_PS, CLK_PS));
  localparam int C_RCD  = imax(1, C_RAC - C_AA);
  localparam int C_CLO  = imax(1, cyc_ceil(imax(T_CAS_PS, T_CAC_PS), CLK_PS));
  localparam int C_CHI  = imax(1, imax(C_AA - 1 - C_CLO, C_PC - 1 - C_CLO));
  localparam int C_RASM = imax(C_RC - C_RP, C_RCD + 1 + C_CLO + C_CHI);
  localparam int C_REFI = imax(2, cyc_ceil(T_REFI_PS, CLK_PS));

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             ref_pend;
  logic             ref_clr;

  edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr (req_addr),
    .row  (req_row),
    .col  (req_col)
  );

  edo_refresh_timer #(.INTERVAL(C_REFI)) u_refresh (
    .clk  (clk),
    .rst  (rst),
    .clr  (ref_clr),
    .pend (ref_pend)
  );

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W),
    .RCD(C_RCD), .CLO(C_CLO), .CHI(C_CHI), .RP(C_RP), .RAS_MIN(C_RASM)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_row     (req_row),
    .req_col     (req_col),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .ref_pend    (ref_pend),
    .ref_clr     (ref_clr),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_oe_n   (dram_oe_n),
    .dram_dq_in  (dram_dq_in),
    .dram_dq_out (dram_dq_out),
    .dram_dq_oe  (dram_dq_oe),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

  // R9: no host request is taken while a refresh waits
  assert_refresh_first_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(ref_pend) && ref_pend) |-> !(req_valid && req_ready));

endmodule

// File: tb/edo_page_ctrl_bench.sv
`timescale 1ns/1ps
module edo_page_ctrl_bench;
  localparam int ROW_W = 4;
  localparam int COL_W = 3;
  localparam int AW    = ROW_W + COL_W;
  localparam int PW    = 4;
  localparam int B_RP     = (30000 + 4999) / 5000;
  localparam int B_RASMIN = (84000 + 4999) / 5000 - B_RP;
  localparam int B_CLO    = (13000 + 4999) / 5000;
  localparam int B_REFI   = 1000000 / 5000;
  localparam int B_LIMIT  = B_REFI + 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [7:0] rd_data;
  logic [PW-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0] dram_dq_out;
  logic [7:0] dq_in_r = 8'hEE;

  always #2.5 clk = ~clk;

  edo_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_REFI_PS(1000000)) u_edo_page_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_in(dq_in_r), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  // scoreboard queues
  logic [AW-1:0] exp_addr_q[$];
  bit            exp_wr_q[$];
  logic [7:0]    exp_wd_q[$];
  logic [7:0]    rd_q[$];
  logic [7:0]    shadow [0:(1<<AW)-1];
  logic [7:0]    mem    [0:(1<<AW)-1];

  // behavioural DRAM model
  logic prv_ras = 1'b1, prv_cas = 1'b1, prv_we = 1'b1;
  int hi_len = 100, lo_len = 0, clo_len = 0;
  logic [ROW_W-1:0] m_row = '0;
  int act_cnt = 0, col_cnt = 0, ref_cnt = 0, cyc = 0, last_ref = 0;
  logic [AW-1:0] ea;
  bit ew;
  logic [7:0] ed, er;

  always @(negedge clk) begin
    if (rst) begin
      prv_ras = 1'b1; prv_cas = 1'b1; prv_we = 1'b1;
      hi_len = 100; lo_len = 0; clo_len = 0; cyc = 0; last_ref = 0;
    end else begin
      cyc++;
      if (dram_ras_n || dram_oe_n) dq_in_r = 8'hEE;
      if (prv_ras && !dram_ras_n) begin
        if (!dram_cas_n) begin
          check(!prv_cas && dram_we_n, "R8", "refresh cas-first/we", {prv_cas, dram_we_n}, 1);
          check(cyc - last_ref <= B_LIMIT, "R8", "refresh spacing", cyc - last_ref, B_LIMIT);
          last_ref = cyc;
          ref_cnt++;
        end else begin
          check(hi_len >= B_RP, "R4", "row precharge cycles", hi_len, B_RP);
          m_row = dram_addr[ROW_W-1:0];
          act_cnt++;
        end
      end
      if (!prv_ras && dram_ras_n)
        check(lo_len >= B_RASMIN, "R5", "row strobe low cycles", lo_len, B_RASMIN);
      if (!prv_cas && dram_cas_n)
        check(clo_len >= B_CLO, "R5", "column strobe low cycles", clo_len, B_CLO);
      if (prv_cas && !dram_cas_n && !dram_ras_n) begin
        col_cnt++;
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "R1", "column access with no request", 1, 0);
        end else begin
          ea = exp_addr_q.pop_front(); ew = exp_wr_q.pop_front(); ed = exp_wd_q.pop_front();
          check({m_row, dram_addr[COL_W-1:0]} == ea, "R1", "row/column address",
                int'({m_row, dram_addr[COL_W-1:0]}), int'(ea));
          check((!dram_we_n) == ew, "R6", "write strobe level", int'(!dram_we_n), int'(ew));
          if (!dram_we_n) begin
            check(!prv_we && dram_dq_oe && dram_oe_n, "R6", "write setup/drive",
                  {prv_we, dram_dq_oe, dram_oe_n}, 3);
            check(dram_dq_out == ed, "R2", "write data on bus", dram_dq_out, ed);
            mem[{m_row, dram_addr[COL_W-1:0]}] = dram_dq_out;
          end else begin
            check(!dram_oe_n, "R7", "output enable in read", dram_oe_n, 0);
            check(!dram_dq_oe, "R10", "bus released in read", dram_dq_oe, 0);
            dq_in_r = mem[{m_row, dram_addr[COL_W-1:0]}];
          end
        end
      end
      if (dram_ras_n) begin hi_len++; lo_len = 0; end
      else begin lo_len++; hi_len = 0; end
      if (dram_cas_n) clo_len = 0; else clo_len++;
      prv_ras = dram_ras_n; prv_cas = dram_cas_n; prv_we = dram_we_n;
    end
  end

  // monitor: read results against scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (rd_q.size() == 0) begin
        check(1'b0, "R2", "unexpected read strobe", rd_data, -1);
      end else begin
        er = rd_q.pop_front();
        check(rd_data == er, "R2", "read data", rd_data, er);
      end
    end
  end

  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [7:0] d);
    exp_addr_q.push_back(a); exp_wr_q.push_back(wr); exp_wd_q.push_back(d);
    if (wr) shadow[a] = d; else rd_q.push_back(shadow[a]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain;
    while (rd_q.size() != 0 || exp_addr_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_refresh;
    int r0;
    r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk);
    repeat (B_RP + 2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int a0, c0;
    logic [15:0] lf;
    for (int i = 0; i < (1 << AW); i++) begin shadow[i] = 8'h00; mem[i] = 8'h00; end
    repeat (4) @(negedge clk);
    // R9: reset values
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R9", "strobes idle in reset",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    check(!dram_dq_oe && !rd_valid, "R9", "bus/strobe quiet in reset", {dram_dq_oe, rd_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready, "R9", "ready after reset", req_ready, 1);

    // R1/R2: writes across rows then reads back
    for (int i = 0; i < 8; i++) send(1'b1, AW'(i * 19 + 3), 8'(8'h30 + i * 7));
    for (int i = 7; i >= 0; i--) send(1'b0, AW'(i * 19 + 3), 8'h00);
    drain();

    // R3: page hits after a fresh refresh
    wait_refresh();
    a0 = act_cnt; c0 = col_cnt;
    send(1'b1, {4'd5, 3'd1}, 8'hA1);
    send(1'b0, {4'd5, 3'd1}, 8'h00);
    send(1'b1, {4'd5, 3'd6}, 8'h6B);
    send(1'b0, {4'd5, 3'd6}, 8'h00);
    drain();
    check(act_cnt - a0 == 1, "R3", "activations for one-row burst", act_cnt - a0, 1);
    check(col_cnt - c0 == 4, "R3", "column accesses in burst", col_cnt - c0, 4);

    // R4: alternating rows force a miss each time
    wait_refresh();
    a0 = act_cnt;
    send(1'b0, {4'd1, 3'd2}, 8'h00);
    send(1'b0, {4'd2, 3'd2}, 8'h00);
    send(1'b0, {4'd1, 3'd3}, 8'h00);
    send(1'b0, {4'd2, 3'd4}, 8'h00);
    drain();
    check(act_cnt - a0 == 4, "R4", "activations for alternating rows", act_cnt - a0, 4);

    // R9/R8: long uninterrupted hit stream on one row
    for (int i = 0; i < 120; i++) begin
      if (i % 2 == 0) send(1'b1, {4'd9, 3'(i / 2)}, 8'(i * 13 + 1));
      else            send(1'b0, {4'd9, 3'(i / 2)}, 8'h00);
    end
    drain();

    // mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(lf[0], AW'(lf[9:3]), lf[15:8]);
    end
    drain();

    check(ref_cnt >= cyc / B_LIMIT, "R8", "refresh count", ref_cnt, cyc / B_LIMIT);
    check(cyc - last_ref <= B_LIMIT, "R8", "time since last refresh", cyc - last_ref, B_LIMIT);
    check(rd_q.size() == 0, "R2", "reads outstanding", rd_q.size(), 0);
    summary();
    $finish;
  end
endmodule